// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block adds or subtracts two 32-bit operands as packed lanes: four unsigned bytes, two 16-bit halves (signed or unsigned) or one signed 32-bit word. Lanes are computed side by side with no carry between them. Each operation runs in one of four arithmetic modes: wrapping, saturating, halving, or halving with rounding. The result is registered and appears one clock after the request, together with a valid strobe.

Each lane flags its own range error. In the wrapping and saturating modes, a range error in any lane sets a sticky overflow flag at bit 20 of a 32-bit control word. Software reads the whole word back and can overwrite it through a write port, which is the only way to clear the flag. The other 31 bits of the word are plain storage that the arithmetic never changes.

Top module: `pksat_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_data`, `res_valid` and `ctl_rdata` all become zero.
- R2: When `op_valid` is high at an edge, `res_valid` is high and `res_data` holds that operation's result after the edge. When `op_valid` is low, `res_valid` goes low and `res_data` keeps its value.
- R3: When `op_mode` = 0 (wrap), each lane returns the low lane bits of a+b, or of a-b when `op_sub` = 1. No carry or borrow crosses a lane boundary.
- R4: When `op_mode` = 1 (saturate) and a lane is signed, a signed range error gives 0x7FFF or 0x7FFFFFFF if the first operand of that lane is greater than zero. Otherwise it gives 0x8000 or 0x80000000, so 0 - 0x8000 yields 0x8000.
- R5: When `op_mode` = 1 and a lane is unsigned, a carry out of an add gives all ones (0xFF or 0xFFFF), and a borrow out of a subtract gives zero.
- R6: When `op_mode` = 2, the lane is the full-precision sum or difference shifted right by one. When `op_mode` = 3, 1 is added before that shift. Neither mode touches the overflow flag.
- R7: A range error in any active lane in mode 0 or 1 sets `ctl_rdata[20]`. Nothing but a write clears it, and the arithmetic leaves every other bit of `ctl_rdata` unchanged.
- R8: When `ctl_wr` is high at an edge, the control word loads `ctl_wdata`. If an operation in the same cycle raises a range error, bit 20 is still set on top of the written value.
- R9: `op_width` = 0 selects four byte lanes, and these are always unsigned, whatever `op_signed` says. `op_width` = 1 selects two 16-bit lanes whose signedness follows `op_signed`. `op_width` = 2 or 3 selects one 32-bit lane, which is always signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request this cycle |
| op_width | input | 2 | Lane width select (0 byte, 1 half, 2/3 word) |
| op_signed | input | 1 | Signed lanes for 16-bit width |
| op_sub | input | 1 | 1 = a - b, 0 = a + b |
| op_mode | input | 2 | 0 wrap, 1 saturate, 2 halve, 3 halve and round |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| res_valid | output | 1 | Result strobe |
| res_data | output | 32 | Registered packed result |
| ctl_wr | input | 1 | Control word write enable |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Control word; bit 20 is the sticky overflow flag |

## Verification
Directed operands sit on the lane limits: 0x7FFF, 0x8000, 0xFF, 0xFFFF and zero, including a lane one step past its limit next to a quiet lane. These show whether a carry leaks across a lane boundary and whether saturation goes in the right direction, including the zero-minus-most-negative case. Halving vectors at the extremes show whether the sum is kept at full precision and whether the rounding increment is applied. Random words mixed with replicated corner halves cover every width, signedness and mode pairing. After each vector the whole control word is compared, so the sticky flag and the untouched bits are checked every time.

// File: rtl/pksat_pkg.sv
// Shared encodings for the packed saturating lane adder.
// Assumes a 32-bit control word with the sticky flag at a fixed bit.
package pksat_pkg;
    localparam int CTL_W       = 32;
    localparam int CTL_OVF_BIT = 20;

    typedef enum logic [1:0] {
        MODE_WRAP     = 2'd0,
        MODE_SAT      = 2'd1,
        MODE_HALF     = 2'd2,
        MODE_HALF_RND = 2'd3
    } arith_mode_e;

    localparam logic [1:0] WID_BYTE = 2'd0;
    localparam logic [1:0] WID_HALF = 2'd1;
endpackage

// File: rtl/pksat_lane.sv
// One arithmetic lane of width W: add/sub with wrap, saturate or halve.
// Assumes the caller resolves signedness; purely combinational.
module pksat_lane
    import pksat_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    input  logic         is_sub,
    input  arith_mode_e  mode,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int XW = W + 2;

    logic [XW-1:0] ea, eb, full;
    logic          range_err;
    logic          a_pos;
    logic [W-1:0]  pos_lim, neg_lim, sat_val;

    // Extend both operands two bits so the exact result fits.
    always_comb begin
        ea   = is_signed ? {{2{a[W-1]}}, a} : {2'b00, a};
        eb   = is_signed ? {{2{b[W-1]}}, b} : {2'b00, b};
        full = is_sub ? (ea - eb) : (ea + eb);
    end

    // Detect a result outside the lane range and pick the clamp value.
    always_comb begin
        range_err = is_signed ? (full[W] != full[W-1]) : (full[W+1] | full[W]);
        a_pos     = ~a[W-1] & (|a);
        pos_lim   = {1'b0, {(W-1){1'b1}}};
        neg_lim   = {1'b1, {(W-1){1'b0}}};
        if (is_signed)
            sat_val = a_pos ? pos_lim : neg_lim;
        else
            sat_val = is_sub ? '0 : '1;
    end

    // Select the lane result by mode; halving adds the dropped bit when rounding.
    always_comb begin
        case (mode)
            MODE_WRAP:     res = full[W-1:0];
            MODE_SAT:      res = range_err ? sat_val : full[W-1:0];
            MODE_HALF:     res = full[W:1];
            default:       res = full[W:1] + W'(full[0]);
        endcase
        ovf = range_err & ~mode[1];
    end
endmodule

// File: rtl/pksat_ctl.sv
// Control word: software-writable storage with a sticky overflow flag.
// Assumes the write and the overflow set may coincide; the set wins for its bit.
module pksat_ctl
    import pksat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             set_ovf,
    output logic [CTL_W-1:0] rdata
);
    logic [CTL_W-1:0] ctl_q;

    // Load on write, otherwise keep; OR in the sticky flag on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= (wr ? wdata : ctl_q) | (CTL_W'(set_ovf) << CTL_OVF_BIT);
        end
    end

    assign rdata = ctl_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && rdata[CTL_OVF_BIT]) |=> rdata[CTL_OVF_BIT]); // R7
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !set_ovf) |=> (rdata == $past(wdata))); // R8
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> rdata[CTL_OVF_BIT]); // R7
endmodule

// File: rtl/pksat_alu.sv
// Packed lane adder top: byte, half and word lanes side by side, width mux,
// one-cycle result register and control word. Assumes DATA_W is a multiple of 16.
module pksat_alu
    import pksat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_width,
    input  logic              op_signed,
    input  logic              op_sub,
    input  logic [1:0]        op_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata
);
    localparam int N8  = DATA_W / 8;
    localparam int N16 = DATA_W / 16;

    arith_mode_e              mode;
    logic [N8-1:0][7:0]       r8;
    logic [N16-1:0][15:0]     r16;
    logic [DATA_W-1:0]        r32;
    logic [N8-1:0]            o8;
    logic [N16-1:0]           o16;
    logic                     o32;
    logic [DATA_W-1:0]        sel_res;
    logic                     sel_ovf;

    assign mode = arith_mode_e'(op_mode);

    // Byte lanes are always unsigned.
    for (genvar g = 0; g < N8; g++) begin : g_byte
        pksat_lane #(.W(8)) u_lane (
            .a(src_a[g*8 +: 8]), .b(src_b[g*8 +: 8]),
            .is_signed(1'b0), .is_sub(op_sub), .mode(mode),
            .res(r8[g]), .ovf(o8[g])
        );
    end

    // Half lanes follow the signed request.
    for (genvar g = 0; g < N16; g++) begin : g_half
        pksat_lane #(.W(16)) u_lane (
            .a(src_a[g*16 +: 16]), .b(src_b[g*16 +: 16]),
            .is_signed(op_signed), .is_sub(op_sub), .mode(mode),
            .res(r16[g]), .ovf(o16[g])
        );
    end

    // The full-word lane is always signed.
    pksat_lane #(.W(DATA_W)) u_word (
        .a(src_a), .b(src_b), .is_signed(1'b1), .is_sub(op_sub), .mode(mode),
        .res(r32), .ovf(o32)
    );

    // Pick the result and overflow of the requested lane width.
    always_comb begin
        case (op_width)
            WID_BYTE: begin sel_res = r8;  sel_ovf = |o8;  end
            WID_HALF: begin sel_res = r16; sel_ovf = |o16; end
            default:  begin sel_res = r32; sel_ovf = o32;  end
        endcase
    end

    // Register the result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) res_data <= sel_res;
        end
    end

    pksat_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .set_ovf(op_valid & sel_ovf), .rdata(ctl_rdata)
    );

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_data))); // R2
    AST_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode[1] && !ctl_wr && !ctl_rdata[CTL_OVF_BIT])
        |=> !ctl_rdata[CTL_OVF_BIT]); // R6
endmodule

// File: tb/test_pksat_alu.sv
module test_pksat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_width = '0;
    logic        op_signed = 1'b0;
    logic        op_sub = 1'b0;
    logic [1:0]  op_mode = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] shadow = '0;
    logic [31:0] last_res = '0;

    pksat_alu i_pksat_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_width(op_width),
        .op_signed(op_signed), .op_sub(op_sub), .op_mode(op_mode),
        .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    always #4 clk = ~clk;

    // Reference: {overflow, result} from the requirement text.
    function automatic logic [32:0] ref_op(input logic [1:0] w, input logic sgn,
            input logic sub, input logic [1:0] md, input logic [31:0] a, b);
        int lw; logic eff; logic [31:0] res = '0; logic ov = 1'b0;
        case (w)
            2'd0:    begin lw = 8;  eff = 1'b0; end
            2'd1:    begin lw = 16; eff = sgn;  end
            default: begin lw = 32; eff = 1'b1; end
        endcase
        for (int i = 0; i < 32 / lw; i++) begin
            longint mask, x, y, r, mx, mn, lr;
            logic lo;
            mask = (longint'(1) << lw) - 1;
            x = longint'(a >> (i * lw)) & mask;
            y = longint'(b >> (i * lw)) & mask;
            if (eff && x > mask / 2) x = x - (mask + 1);
            if (eff && y > mask / 2) y = y - (mask + 1);
            r  = sub ? x - y : x + y;
            mx = eff ? mask / 2 : mask;
            mn = eff ? -(mask / 2) - 1 : 0;
            lo = (r > mx) || (r < mn);
            case (md)
                2'd0: begin lr = r; ov |= lo; end
                2'd1: begin
                    lr = !lo ? r : (eff ? (x > 0 ? mx : mn) : (sub ? 0 : mask));
                    ov |= lo;
                end
                2'd2: lr = r >>> 1;
                default: lr = (r + 1) >>> 1;
            endcase
            res = res | 32'((lr & mask) << (i * lw));
        end
        return {ov, res};
    endfunction

    function automatic string tag_for(input logic [1:0] w, input logic sgn, input logic [1:0] md);
        logic eff = (w == 2'd0) ? 1'b0 : ((w == 2'd1) ? sgn : 1'b1);
        if (md >= 2'd2) return "R6";
        if (md == 2'd1) return eff ? "R4" : "R5";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operation at a falling edge; check after the next rising edge.
    task automatic run_op(input logic [1:0] w, input logic sgn, sub, input logic [1:0] md,
            input logic [31:0] a, b, input string tag);
        logic [32:0] e = ref_op(w, sgn, sub, md, a, b);
        op_valid = 1'b1; op_width = w; op_signed = sgn; op_sub = sub; op_mode = md;
        src_a = a; src_b = b;
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0;
        if (md < 2'd2 && e[32]) shadow[20] = 1'b1;
        last_res = e[31:0];
        check(tag, res_data, e[31:0]);
        check("R2", {31'b0, res_valid}, 32'd1);
        check((md >= 2'd2) ? "R6" : "R7", ctl_rdata, shadow);
    endtask

    task automatic ctl_write(input logic [31:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(posedge clk); @(negedge clk);
        ctl_wr = 1'b0;
        shadow = d;
        check("R8", ctl_rdata, shadow);
    endtask

    function automatic logic [31:0] pick_word();
        logic [15:0] c[5] = '{16'h7FFF, 16'h8000, 16'h00FF, 16'h0000, 16'hFFFF};
        case ($urandom % 3)
            0: return {c[$urandom % 5], c[$urandom % 5]};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", res_data, 32'h0);
        check("R1", {31'b0, res_valid}, 32'h0);
        check("R1", ctl_rdata, 32'h0);
        rst_n = 1'b1;

        // R3 wrap: lane overflow without carry across lanes
        run_op(2'd1, 1'b1, 1'b0, 2'd0, 32'h7FFF_0001, 32'h0001_0001, "R3");
        run_op(2'd0, 1'b0, 1'b0, 2'd0, 32'hFF00_FF00, 32'h0100_0100, "R3");
        run_op(2'd1, 1'b0, 1'b1, 2'd0, 32'h0000_0005, 32'h0001_0006, "R3");
        // R8 clear
        ctl_write(32'h0);
        // R4 signed saturation direction
        run_op(2'd1, 1'b1, 1'b0, 2'd1, 32'h7FFF_8000, 32'h0001_FFFF, "R4");
        run_op(2'd1, 1'b1, 1'b1, 2'd1, 32'h0000_8000, 32'h8000_0001, "R4");
        run_op(2'd2, 1'b0, 1'b0, 2'd1, 32'h7FFF_FFFF, 32'h0000_0001, "R4");
        run_op(2'd3, 1'b0, 1'b1, 2'd1, 32'h8000_0000, 32'h0000_0001, "R4");
        // R5 unsigned saturation
        run_op(2'd0, 1'b0, 1'b0, 2'd1, 32'hFF10_FF00, 32'h0120_0000, "R5");
        run_op(2'd0, 1'b0, 1'b1, 2'd1, 32'h0010_0005, 32'h0108_0004, "R5");
        run_op(2'd1, 1'b0, 1'b0, 2'd1, 32'hFFFF_0001, 32'h0001_0002, "R5");
        // R9 byte width ignores signed flag; width 3 is signed word
        run_op(2'd0, 1'b1, 1'b0, 2'd1, 32'h7F80_FF01, 32'h0180_0101, "R9");
        run_op(2'd3, 1'b0, 1'b0, 2'd1, 32'h8000_0000, 32'hFFFF_FFFF, "R9");
        // R6 halving keeps sticky clear
        ctl_write(32'h0);
        run_op(2'd1, 1'b1, 1'b0, 2'd2, 32'h7FFF_8000, 32'h7FFF_8000, "R6");
        run_op(2'd1, 1'b1, 1'b0, 2'd3, 32'h0001_FFFF, 32'h0000_0000, "R6");
        run_op(2'd1, 1'b1, 1'b1, 2'd3, 32'h8000_7FFF, 32'h7FFF_8000, "R6");
        run_op(2'd0, 1'b0, 1'b1, 2'd2, 32'h00FF_0001, 32'hFF00_0002, "R6");
        // R2 idle keeps result
        @(posedge clk); @(negedge clk);
        check("R2", {31'b0, res_valid}, 32'h0);
        check("R2", res_data, last_res);
        // R7 other bits untouched by arithmetic
        ctl_write(32'hA5A5_0F0F & ~32'h0010_0000);
        run_op(2'd1, 1'b0, 1'b0, 2'd0, 32'hFFFF_0000, 32'h0001_0000, "R7");
        // R8 write coinciding with overflow
        ctl_wr = 1'b1; ctl_wdata = 32'h0000_0003;
        op_valid = 1'b1; op_width = 2'd0; op_signed = 1'b0; op_sub = 1'b0; op_mode = 2'd0;
        src_a = 32'h0000_00FF; src_b = 32'h0000_0001;
        @(posedge clk); @(negedge clk);
        ctl_wr = 1'b0; op_valid = 1'b0;
        shadow = 32'h0010_0003;
        check("R8", ctl_rdata, shadow);
        ctl_write(32'h0);

        for (int n = 0; n < 600; n++) begin
            logic [1:0] w = 2'($urandom), md = 2'($urandom);
            logic sg = 1'($urandom), sb = 1'($urandom);
            if (n % 40 == 0) ctl_write($urandom);
            run_op(w, sg, sb, md, pick_word(), pick_word(), tag_for(w, sg, md));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule